// File: doc/BRIEF.md
# Macro-op expanding decode packer

This block sits between fetch and execute in a processor pipeline. Fetch hands it whole instruction lines of IN_W slots. The lines wait in a small FIFO. Each cycle the block packs the slots into one output bundle of OUT_W slots for the next stage. Empty slots are dropped. Faulting slots pass through untouched. A slot flagged as a macro-op is split into a string of micro-ops, one output slot for each. That string may run across several bundles and several cycles, and a micro-op index travels with each piece.

Every instruction or micro-op leaving the block carries a running 16-bit sequence number. The next stage has a buffer with a reservation credit. While it has no room, the block stalls and holds its input. When the block emits a bundle with at least one filled slot, it raises a one-cycle reserve pulse beside that bundle. An input pin selects whether one cycle may carry on into the next buffered line once the current line is used up.

Top module: `decode_packer`

## Requirements
- R1: After reset, every output slot is a bubble (`out_vld` all 0) and `out_rsv` is 0. `drained` is 1 while `in_push` is low. The first emitted item carries sequence number 1.
- R2: A cycle in which `nx_can_rsv` is low is a stall. The bundle registered at the end of that cycle is all bubbles with `out_rsv` 0, and no buffered slot is consumed. The stalled work is emitted unchanged once `nx_can_rsv` returns high.
- R3: A line is pushed while `in_push` is high at a rising edge. It is packed in the following cycle, and its bundle appears on the outputs after the next rising edge. Slots are taken in rising slot order (slot 0 of a line first) and placed into output slots 0 upward. Packing stops when all OUT_W output slots are full, and the remaining slots carry over to the next cycle.
- R4: An input slot with its valid bit at 0 is skipped. It occupies no output slot and ends any macro-op expansion in progress.
- R5: An input slot with its fault bit at 1 takes exactly one output slot, whatever its macro flag says. The output has fault 1, the slot's PC and prediction fields, and micro-op index 0.
- R6: A valid, non-faulting slot with the macro flag at 1 and count field N (3 bits) produces N+1 micro-ops. They all carry the slot's PC, with micro-op indices 0, 1, …, N in order. A count of 0 means one micro-op.
- R7: The input advances past a macro-op only after its last micro-op is emitted. The expansion continues across bundles and stall cycles, and its micro-op index is kept.
- R8: Only the last micro-op of a macro-op carries the slot's predicted-taken flag and target. Earlier micro-ops have taken 0, target 0 and fault 0. A plain slot keeps its own prediction fields.
- R9: Each emitted item receives the current sequence number, and the counter then increases by one. Numbers are gap-free in emission order, across slots and cycles.
- R10: `out_rsv` is 1 exactly when at least one output slot is filled. Filled slots are contiguous from slot 0, and the rest are bubbles.
- R11: With `multi_line_en` at 1, a cycle that finishes a line continues with the next buffered line in the same cycle. With `multi_line_en` at 0, the cycle ends at the line boundary.
- R12: `drained` is 1 exactly when the FIFO holds no line and `in_push` is low.
- R13: The FIFO holds up to DEPTH lines and releases them in push order. A push is accepted only while there is space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_push | input | 1 | Incoming line present this cycle |
| in_vld | input | IN_W | Per-slot valid bit (0 = bubble) |
| in_fault | input | IN_W | Per-slot fault bit |
| in_macro | input | IN_W | Per-slot macro-op flag |
| in_ucnt | input | IN_W*3 | Per-slot micro-op count minus one |
| in_pc | input | IN_W*PC_W | Per-slot PC |
| in_taken | input | IN_W | Per-slot predicted-taken flag |
| in_tgt | input | IN_W*PC_W | Per-slot predicted target |
| multi_line_en | input | 1 | Allow a second line within one cycle |
| nx_can_rsv | input | 1 | Next stage can accept a reservation |
| out_vld | output | OUT_W | Output slot filled |
| out_fault | output | OUT_W | Output slot fault bit |
| out_pc | output | OUT_W*PC_W | Output slot PC |
| out_upc | output | OUT_W*3 | Output slot micro-op index |
| out_taken | output | OUT_W | Output slot predicted-taken |
| out_tgt | output | OUT_W*PC_W | Output slot predicted target |
| out_seq | output | OUT_W*SEQ_W | Output slot sequence number |
| out_rsv | output | 1 | Reserve one entry in the next stage |
| drained | output | 1 | No buffered or incoming line |

## Verification
A line pushed in bench cycle n is registered into the FIFO at edge n+1 and packed during cycle n+1. Its first bundle appears after edge n+2. Each further bundle of the same work, from overflow or from a long macro-op, is due one cycle later, and every stall cycle adds one more. Each expected item goes into the scoreboard with its due cycle, its output slot and all its fields. The monitor samples at the falling edge, so a result that arrives early, arrives late, lands in another slot or appears unexpected is reported. `drained` is combinational on `in_push`, so it is sampled 1 ns after the inputs are driven.

// File: rtl/decode_pkg.sv
package decode_pkg;
  localparam int UCNT_W = 3;
  localparam int UPC_W  = 3;

  // Bit positions inside one flattened input slot
  localparam int F_VLD   = 0;
  localparam int F_FAULT = 1;
  localparam int F_MACRO = 2;
  localparam int F_UCNT  = 3;
  localparam int F_PC    = F_UCNT + UCNT_W;

  typedef enum logic [1:0] {
    SK_BUBBLE,
    SK_FAULT,
    SK_MACRO,
    SK_PLAIN
  } slot_kind_e;

  function automatic int slot_bits(int pc_w);
    return F_PC + 2 * pc_w + 1;
  endfunction

  function automatic slot_kind_e classify(logic vld, logic fault, logic macro);
    if (!vld)       return SK_BUBBLE;
    else if (fault) return SK_FAULT;
    else if (macro) return SK_MACRO;
    else            return SK_PLAIN;
  endfunction
endpackage

// File: rtl/decode_line_fifo.sv
module decode_line_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic [1:0]       pop_cnt,
  output logic [W-1:0]     head,
  output logic [W-1:0]     nxt,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rptr, rptr_nx, wptr, wptr_nx, rptr_p1;
  logic [CNT_W-1:0] cnt_nx;
  logic             wr_en;

  function automatic logic [PTR_W-1:0] wrap_add(logic [PTR_W-1:0] p, int inc);
    int t;
    t = int'(p) + inc;
    if (t >= DEPTH) t = t - DEPTH;
    return PTR_W'(t);
  endfunction

  always_comb begin
    wr_en   = push && (int'(count) < DEPTH);
    rptr_nx = wrap_add(rptr, int'(pop_cnt));
    wptr_nx = wr_en ? wrap_add(wptr, 1) : wptr;
    cnt_nx  = CNT_W'(int'(count) + (wr_en ? 1 : 0) - int'(pop_cnt));
    rptr_p1 = wrap_add(rptr, 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else begin
      rptr  <= rptr_nx;
      wptr  <= wptr_nx;
      count <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= din;
  end

  assign head = mem[rptr];
  assign nxt  = mem[rptr_p1];

  AST_FIFO_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (int'(count) < DEPTH));                     // R13
  AST_FIFO_POP_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_cnt) <= int'(count));                       // R13
endmodule

// File: rtl/decode_pack_core.sv
module decode_pack_core
  import decode_pkg::*;
#(
  parameter int IN_W  = 2,
  parameter int OUT_W = 2,
  parameter int PC_W  = 16,
  parameter int SEQ_W = 16,
  localparam int SLOT_W = slot_bits(PC_W),
  localparam int LINE_W = IN_W * SLOT_W,
  localparam int IDX_W  = (IN_W > 1) ? $clog2(IN_W) : 1,
  localparam int ITER   = OUT_W + 2 * IN_W
) (
  input  logic [LINE_W-1:0]      line0,
  input  logic [LINE_W-1:0]      line1,
  input  logic [1:0]             lines_avail,
  input  logic [IDX_W-1:0]       st_idx,
  input  logic                   st_mac,
  input  logic [UPC_W-1:0]       st_upc,
  input  logic [SEQ_W-1:0]       st_seq,
  output logic [OUT_W-1:0]       o_vld,
  output logic [OUT_W-1:0]       o_fault,
  output logic [OUT_W*PC_W-1:0]  o_pc,
  output logic [OUT_W*UPC_W-1:0] o_upc,
  output logic [OUT_W-1:0]       o_taken,
  output logic [OUT_W*PC_W-1:0]  o_tgt,
  output logic [OUT_W*SEQ_W-1:0] o_seq,
  output logic [IDX_W-1:0]       nx_idx,
  output logic                   nx_mac,
  output logic [UPC_W-1:0]       nx_upc,
  output logic [SEQ_W-1:0]       nx_seq,
  output logic [1:0]             pop_cnt,
  output logic                   any_emit
);
  always_comb begin
    int li, idx, oi, pops;
    logic mac, last, emit, e_fault, e_taken;
    logic [UPC_W-1:0]  upc, e_upc;
    logic [SEQ_W-1:0]  seq;
    logic [SLOT_W-1:0] s;
    logic [PC_W-1:0]   s_pc, s_tgt, e_tgt;
    logic [UCNT_W-1:0] s_ucnt;

    o_vld   = '0;
    o_fault = '0;
    o_pc    = '0;
    o_upc   = '0;
    o_taken = '0;
    o_tgt   = '0;
    o_seq   = '0;
    li   = 0;
    idx  = int'(st_idx);
    oi   = 0;
    pops = 0;
    mac  = st_mac;
    upc  = st_upc;
    seq  = st_seq;
    s    = '0;
    s_pc = '0;
    s_tgt = '0;
    s_ucnt = '0;
    last = 1'b0;
    emit = 1'b0;
    e_fault = 1'b0;
    e_taken = 1'b0;
    e_upc = '0;
    e_tgt = '0;

    for (int it = 0; it < ITER; it++) begin
      if (li < int'(lines_avail) && oi < OUT_W) begin
        s      = (li == 0) ? line0[idx*SLOT_W +: SLOT_W] : line1[idx*SLOT_W +: SLOT_W];
        s_pc   = s[F_PC +: PC_W];
        s_tgt  = s[F_PC+PC_W+1 +: PC_W];
        s_ucnt = s[F_UCNT +: UCNT_W];
        emit   = 1'b0;
        unique case (classify(s[F_VLD], s[F_FAULT], s[F_MACRO]))
          SK_BUBBLE: begin
            idx = idx + 1;
            mac = 1'b0;
          end
          SK_FAULT: begin
            emit    = 1'b1;
            e_fault = 1'b1;
            e_upc   = '0;
            e_taken = s[F_PC+PC_W];
            e_tgt   = s_tgt;
            idx     = idx + 1;
            mac     = 1'b0;
          end
          SK_MACRO: begin
            if (!mac) begin
              upc = '0;
              mac = 1'b1;
            end
            last    = (upc == s_ucnt);
            emit    = 1'b1;
            e_fault = 1'b0;
            e_upc   = upc;
            e_taken = last ? s[F_PC+PC_W] : 1'b0;
            e_tgt   = last ? s_tgt : '0;
            upc     = upc + 1'b1;
            if (last) begin
              idx = idx + 1;
              mac = 1'b0;
            end
          end
          default: begin
            emit    = 1'b1;
            e_fault = 1'b0;
            e_upc   = '0;
            e_taken = s[F_PC+PC_W];
            e_tgt   = s_tgt;
            idx     = idx + 1;
            mac     = 1'b0;
          end
        endcase
        if (emit) begin
          o_vld[oi]                  = 1'b1;
          o_fault[oi]                = e_fault;
          o_pc[oi*PC_W +: PC_W]      = s_pc;
          o_upc[oi*UPC_W +: UPC_W]   = e_upc;
          o_taken[oi]                = e_taken;
          o_tgt[oi*PC_W +: PC_W]     = e_tgt;
          o_seq[oi*SEQ_W +: SEQ_W]   = seq;
          seq = seq + 1'b1;
          oi  = oi + 1;
        end
        if (idx == IN_W) begin
          pops = pops + 1;
          li   = li + 1;
          idx  = 0;
          mac  = 1'b0;
        end
      end
    end

    nx_idx   = IDX_W'(idx);
    nx_mac   = mac;
    nx_upc   = upc;
    nx_seq   = seq;
    pop_cnt  = 2'(pops);
    any_emit = (oi != 0);
  end
endmodule

// File: rtl/decode_bundle_reg.sv
module decode_bundle_reg
  import decode_pkg::*;
#(
  parameter int OUT_W = 2,
  parameter int PC_W  = 16,
  parameter int SEQ_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [OUT_W-1:0]       d_vld,
  input  logic [OUT_W-1:0]       d_fault,
  input  logic [OUT_W*PC_W-1:0]  d_pc,
  input  logic [OUT_W*UPC_W-1:0] d_upc,
  input  logic [OUT_W-1:0]       d_taken,
  input  logic [OUT_W*PC_W-1:0]  d_tgt,
  input  logic [OUT_W*SEQ_W-1:0] d_seq,
  input  logic                   d_rsv,
  output logic [OUT_W-1:0]       q_vld,
  output logic [OUT_W-1:0]       q_fault,
  output logic [OUT_W*PC_W-1:0]  q_pc,
  output logic [OUT_W*UPC_W-1:0] q_upc,
  output logic [OUT_W-1:0]       q_taken,
  output logic [OUT_W*PC_W-1:0]  q_tgt,
  output logic [OUT_W*SEQ_W-1:0] q_seq,
  output logic                   q_rsv
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld   <= '0;
      q_fault <= '0;
      q_pc    <= '0;
      q_upc   <= '0;
      q_taken <= '0;
      q_tgt   <= '0;
      q_seq   <= '0;
      q_rsv   <= 1'b0;
    end else begin
      q_vld   <= d_vld;
      q_fault <= d_fault;
      q_pc    <= d_pc;
      q_upc   <= d_upc;
      q_taken <= d_taken;
      q_tgt   <= d_tgt;
      q_seq   <= d_seq;
      q_rsv   <= d_rsv;
    end
  end
endmodule

// File: rtl/decode_packer.sv
module decode_packer
  import decode_pkg::*;
#(
  parameter int IN_W  = 2,
  parameter int OUT_W = 2,
  parameter int DEPTH = 4,
  parameter int PC_W  = 16,
  parameter int SEQ_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_push,
  input  logic [IN_W-1:0]        in_vld,
  input  logic [IN_W-1:0]        in_fault,
  input  logic [IN_W-1:0]        in_macro,
  input  logic [IN_W*UCNT_W-1:0] in_ucnt,
  input  logic [IN_W*PC_W-1:0]   in_pc,
  input  logic [IN_W-1:0]        in_taken,
  input  logic [IN_W*PC_W-1:0]   in_tgt,
  input  logic                   multi_line_en,
  input  logic                   nx_can_rsv,
  output logic [OUT_W-1:0]       out_vld,
  output logic [OUT_W-1:0]       out_fault,
  output logic [OUT_W*PC_W-1:0]  out_pc,
  output logic [OUT_W*UPC_W-1:0] out_upc,
  output logic [OUT_W-1:0]       out_taken,
  output logic [OUT_W*PC_W-1:0]  out_tgt,
  output logic [OUT_W*SEQ_W-1:0] out_seq,
  output logic                   out_rsv,
  output logic                   drained
);
  localparam int SLOT_W = slot_bits(PC_W);
  localparam int LINE_W = IN_W * SLOT_W;
  localparam int IDX_W  = (IN_W > 1) ? $clog2(IN_W) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [LINE_W-1:0]      line_in, line0, line1;
  logic [CNT_W-1:0]       count;
  logic [1:0]             pop_cnt, lines_avail;
  logic                   blocked, st_en, any_emit;
  logic [IDX_W-1:0]       st_idx, nx_idx;
  logic                   st_mac, nx_mac;
  logic [UPC_W-1:0]       st_upc, nx_upc;
  logic [SEQ_W-1:0]       st_seq, nx_seq;
  logic [OUT_W-1:0]       c_vld, c_fault, c_taken;
  logic [OUT_W*PC_W-1:0]  c_pc, c_tgt;
  logic [OUT_W*UPC_W-1:0] c_upc;
  logic [OUT_W*SEQ_W-1:0] c_seq;
  logic [SEQ_W-1:0]       chk_seq;

  for (genvar g = 0; g < IN_W; g++) begin : g_slot
    assign line_in[g*SLOT_W +: SLOT_W] = {in_tgt[g*PC_W +: PC_W], in_taken[g],
                                          in_pc[g*PC_W +: PC_W],
                                          in_ucnt[g*UCNT_W +: UCNT_W],
                                          in_macro[g], in_fault[g], in_vld[g]};
  end

  decode_line_fifo #(.W(LINE_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(in_push), .din(line_in),
    .pop_cnt(pop_cnt), .head(line0), .nxt(line1), .count(count)
  );

  always_comb begin
    blocked = !nx_can_rsv;
    st_en   = !blocked;
    if (blocked || count == '0)               lines_avail = 2'd0;
    else if (count == CNT_W'(1) || !multi_line_en) lines_avail = 2'd1;
    else                                      lines_avail = 2'd2;
  end

  decode_pack_core #(.IN_W(IN_W), .OUT_W(OUT_W), .PC_W(PC_W), .SEQ_W(SEQ_W)) u_core (
    .line0(line0), .line1(line1), .lines_avail(lines_avail),
    .st_idx(st_idx), .st_mac(st_mac), .st_upc(st_upc), .st_seq(st_seq),
    .o_vld(c_vld), .o_fault(c_fault), .o_pc(c_pc), .o_upc(c_upc),
    .o_taken(c_taken), .o_tgt(c_tgt), .o_seq(c_seq),
    .nx_idx(nx_idx), .nx_mac(nx_mac), .nx_upc(nx_upc), .nx_seq(nx_seq),
    .pop_cnt(pop_cnt), .any_emit(any_emit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_idx <= '0;
      st_mac <= 1'b0;
      st_upc <= '0;
      st_seq <= SEQ_W'(1);
    end else if (st_en) begin
      st_idx <= nx_idx;
      st_mac <= nx_mac;
      st_upc <= nx_upc;
      st_seq <= nx_seq;
    end
  end

  decode_bundle_reg #(.OUT_W(OUT_W), .PC_W(PC_W), .SEQ_W(SEQ_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .d_vld(c_vld), .d_fault(c_fault), .d_pc(c_pc), .d_upc(c_upc),
    .d_taken(c_taken), .d_tgt(c_tgt), .d_seq(c_seq), .d_rsv(any_emit),
    .q_vld(out_vld), .q_fault(out_fault), .q_pc(out_pc), .q_upc(out_upc),
    .q_taken(out_taken), .q_tgt(out_tgt), .q_seq(out_seq), .q_rsv(out_rsv)
  );

  assign drained = (count == '0) && !in_push;

  // Checker state: next sequence number expected at the outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_seq <= SEQ_W'(1);
    else if (out_rsv) chk_seq <= chk_seq + SEQ_W'($countones(out_vld));
  end

  AST_BLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !nx_can_rsv |=> !out_rsv);                                   // R2
  AST_BLOCK_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !nx_can_rsv |-> (pop_cnt == 2'd0));                          // R2
  AST_RSV_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_rsv |-> out_vld[0]);                                     // R10
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_rsv |-> (out_vld == '0));                               // R10
  AST_SEQ_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    out_rsv |-> (out_seq[SEQ_W-1:0] == chk_seq));                // R9
endmodule

// File: tb/test_decode_packer.sv
module test_decode_packer;
  localparam int IN_W = 2, OUT_W = 2, PC_W = 16, SEQ_W = 16;

  typedef struct packed {
    logic vld, fault, macro;
    logic [2:0] ucnt;
    logic [15:0] pc;
    logic taken;
    logic [15:0] tgt;
  } bslot_t;

  typedef struct {
    int due, slot, req;
    logic [15:0] pc, tgt, seq;
    logic [2:0] upc;
    logic fault, taken;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic in_push = 0, multi_line_en = 1, nx_can_rsv = 1;
  logic [IN_W-1:0] in_vld = '0, in_fault = '0, in_macro = '0, in_taken = '0;
  logic [IN_W*3-1:0] in_ucnt = '0;
  logic [IN_W*PC_W-1:0] in_pc = '0, in_tgt = '0;
  logic [OUT_W-1:0] out_vld, out_fault, out_taken;
  logic [OUT_W*PC_W-1:0] out_pc, out_tgt;
  logic [OUT_W*3-1:0] out_upc;
  logic [OUT_W*SEQ_W-1:0] out_seq;
  logic out_rsv, drained;

  int cyc = 0, vectors = 0, errors = 0, n = 0;
  logic [15:0] exp_seq = 16'd1;
  bit done = 0;
  item_t q[$];
  item_t e;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  decode_packer i_decode_packer (
    .clk(clk), .rst_n(rst_n), .in_push(in_push), .in_vld(in_vld),
    .in_fault(in_fault), .in_macro(in_macro), .in_ucnt(in_ucnt),
    .in_pc(in_pc), .in_taken(in_taken), .in_tgt(in_tgt),
    .multi_line_en(multi_line_en), .nx_can_rsv(nx_can_rsv),
    .out_vld(out_vld), .out_fault(out_fault), .out_pc(out_pc),
    .out_upc(out_upc), .out_taken(out_taken), .out_tgt(out_tgt),
    .out_seq(out_seq), .out_rsv(out_rsv), .drained(drained)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  function automatic bslot_t plain(logic [15:0] pc, logic tk, logic [15:0] tg);
    return '{vld:1'b1, fault:1'b0, macro:1'b0, ucnt:3'd0, pc:pc, taken:tk, tgt:tg};
  endfunction
  function automatic bslot_t mac(logic [2:0] u, logic [15:0] pc, logic tk, logic [15:0] tg);
    return '{vld:1'b1, fault:1'b0, macro:1'b1, ucnt:u, pc:pc, taken:tk, tgt:tg};
  endfunction
  function automatic bslot_t bub();
    return '0;
  endfunction

  // Scoreboard driver side: queue one expected item
  task automatic expect_item(input int due, input int slot, input logic [15:0] pc,
                             input logic [2:0] upc, input logic flt, input logic tk,
                             input logic [15:0] tg, input int req);
    item_t it;
    it.due = due; it.slot = slot; it.req = req; it.pc = pc; it.tgt = tg;
    it.seq = exp_seq; it.upc = upc; it.fault = flt; it.taken = tk;
    exp_seq = exp_seq + 16'd1;
    q.push_back(it);
  endtask

  task automatic set_slot(input int g, input bslot_t s);
    in_vld[g] = s.vld; in_fault[g] = s.fault; in_macro[g] = s.macro;
    in_ucnt[g*3 +: 3] = s.ucnt; in_pc[g*PC_W +: PC_W] = s.pc;
    in_taken[g] = s.taken; in_tgt[g*PC_W +: PC_W] = s.tgt;
  endtask

  // Called at a falling edge; returns at the next falling edge with in_push low
  task automatic push2(input bslot_t a, input bslot_t b);
    set_slot(0, a);
    set_slot(1, b);
    in_push = 1;
    #1 chk(!drained, "R12 push", int'(drained), 0);
    @(negedge clk);
    in_push = 0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  // Scoreboard monitor side
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(out_rsv == (out_vld != '0), "R10 rsv", int'(out_rsv), int'(out_vld != '0));
      chk((out_vld & (out_vld + 1'b1)) == '0, "R10 packed", int'(out_vld), 1);
      for (int i = 0; i < OUT_W; i++) begin
        if (out_vld[i]) begin
          if (q.size() == 0) begin
            chk(0, "R2 unexpected item", int'(out_pc[i*PC_W +: PC_W]), 0);
          end else begin
            e = q.pop_front();
            vectors++;
            if (e.due != cyc || e.slot != i || e.pc != out_pc[i*PC_W +: PC_W] ||
                e.upc != out_upc[i*3 +: 3] || e.fault != out_fault[i] ||
                e.taken != out_taken[i] || e.tgt != out_tgt[i*PC_W +: PC_W] ||
                e.seq != out_seq[i*SEQ_W +: SEQ_W]) begin
              errors++;
              $display("FAIL R%0d: actual cyc %0d slot %0d pc %h upc %0d f %b t %b tg %h seq %0d expected cyc %0d slot %0d pc %h upc %0d f %b t %b tg %h seq %0d",
                       e.req, cyc, i, out_pc[i*PC_W +: PC_W], out_upc[i*3 +: 3],
                       out_fault[i], out_taken[i], out_tgt[i*PC_W +: PC_W],
                       out_seq[i*SEQ_W +: SEQ_W], e.due, e.slot, e.pc, e.upc,
                       e.fault, e.taken, e.tgt, e.seq);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    report();
  end

  initial begin
    idle(2);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(out_vld == '0, "R1 vld", int'(out_vld), 0);
    chk(!out_rsv, "R1 rsv", int'(out_rsv), 0);
    chk(drained, "R1 drained", int'(drained), 1);

    // R3 R9: two plain slots in one bundle, first seq is 1
    n = cyc;
    expect_item(n+2, 0, 16'h0100, 0, 0, 0, 16'h0, 3);
    expect_item(n+2, 1, 16'h0104, 0, 0, 0, 16'h0, 9);
    push2(plain(16'h0100, 0, 0), plain(16'h0104, 0, 0));
    idle(5);

    // R4: bubble slot skipped, valid slot lands in output slot 0
    n = cyc;
    expect_item(n+2, 0, 16'h0200, 0, 0, 0, 16'h0, 4);
    push2(bub(), plain(16'h0200, 0, 0));
    idle(5);

    // R5: faulting macro slot passes in one slot; R8 plain keeps prediction
    n = cyc;
    expect_item(n+2, 0, 16'h0300, 0, 1, 1, 16'h03F0, 5);
    expect_item(n+2, 1, 16'h0304, 0, 0, 1, 16'h03C0, 8);
    push2('{vld:1'b1, fault:1'b1, macro:1'b1, ucnt:3'd5, pc:16'h0300, taken:1'b1, tgt:16'h03F0},
          plain(16'h0304, 1, 16'h03C0));
    idle(5);

    // R6 R7 R8: five micro-ops over three bundles, then plain slot
    n = cyc;
    expect_item(n+2, 0, 16'h0400, 0, 0, 0, 16'h0, 6);
    expect_item(n+2, 1, 16'h0400, 1, 0, 0, 16'h0, 8);
    expect_item(n+3, 0, 16'h0400, 2, 0, 0, 16'h0, 7);
    expect_item(n+3, 1, 16'h0400, 3, 0, 0, 16'h0, 7);
    expect_item(n+4, 0, 16'h0400, 4, 0, 1, 16'h0480, 8);
    expect_item(n+4, 1, 16'h0404, 0, 0, 0, 16'h0, 3);
    push2(mac(3'd4, 16'h0400, 1, 16'h0480), plain(16'h0404, 0, 0));
    idle(6);

    // R11 R13 R2: two lines buffered under stall, multi-line continues
    nx_can_rsv = 0;
    n = cyc;
    expect_item(n+3, 0, 16'h0500, 0, 0, 0, 16'h0, 11);
    expect_item(n+3, 1, 16'h0508, 0, 0, 0, 16'h0, 11);
    expect_item(n+4, 0, 16'h050C, 0, 0, 0, 16'h0, 13);
    push2(plain(16'h0500, 0, 0), bub());
    push2(plain(16'h0508, 0, 0), plain(16'h050C, 0, 0));
    #1;
    chk(!out_rsv, "R2 stall bundle", int'(out_rsv), 0);
    chk(!drained, "R12 buffered", int'(drained), 0);
    nx_can_rsv = 1;
    idle(6);

    // R11: single-line mode stops at the line boundary
    multi_line_en = 0;
    nx_can_rsv = 0;
    n = cyc;
    expect_item(n+3, 0, 16'h0600, 0, 0, 0, 16'h0, 11);
    expect_item(n+4, 0, 16'h0608, 0, 0, 0, 16'h0, 11);
    push2(plain(16'h0600, 0, 0), bub());
    push2(plain(16'h0608, 0, 0), bub());
    nx_can_rsv = 1;
    idle(6);
    multi_line_en = 1;

    // R2 R7: stall in the middle of a macro-op keeps its micro-op index
    n = cyc;
    expect_item(n+2, 0, 16'h0700, 0, 0, 0, 16'h0, 7);
    expect_item(n+2, 1, 16'h0700, 1, 0, 0, 16'h0, 7);
    expect_item(n+5, 0, 16'h0700, 2, 0, 1, 16'h07A0, 2);
    push2(mac(3'd2, 16'h0700, 1, 16'h07A0), bub());
    @(negedge clk);
    nx_can_rsv = 0;
    @(negedge clk);
    chk(!out_rsv, "R2 mid-macro stall", int'(out_rsv), 0);
    @(negedge clk);
    nx_can_rsv = 1;
    idle(6);

    // R6: count 0 gives one micro-op carrying the prediction
    n = cyc;
    expect_item(n+2, 0, 16'h0800, 0, 0, 1, 16'h0880, 6);
    expect_item(n+2, 1, 16'h0804, 0, 0, 0, 16'h0, 9);
    push2(mac(3'd0, 16'h0800, 1, 16'h0880), plain(16'h0804, 0, 0));
    idle(6);

    // R9: everything delivered; R12 drained again
    chk(q.size() == 0, "R9 all items delivered", q.size(), 0);
    #1 chk(drained, "R12 idle", int'(drained), 1);
    report();
  end
endmodule